// File: doc/BRIEF.md
# Ripple Bit-Slice Four-Function ALU

This block is a small combinational arithmetic logic unit. It is built as a chain of identical one-bit slices. Each slice holds a full adder made only from gate primitives and a selector that picks one of four functions. The slices are cascaded: the carry leaving each slice enters the next slice up, and the carry entering the lowest slice is held at zero.

A 2-bit function code picks one of four operations:
- copy operand A through unchanged;
- add A and B;
- take the bitwise AND of A and B;
- invert A bit by bit.

Only addition drives the carry chain. For the other three codes, every slice masks its outgoing carry, so the carry-out flag reads zero. There is no clock and no state: the outputs follow the inputs as soon as they settle. The unit is meant to sit inside a larger datapath, which registers its operands and result as that datapath needs.

Top module: `bsalu_top`

## Requirements
- R1: With function code 2'b00, the result equals operand A and the carry flag is 0.
- R2: With function code 2'b01, the result equals the low WIDTH bits of A+B and the carry flag equals bit WIDTH of that sum.
- R3: With function code 2'b10, the result equals the bitwise AND of A and B and the carry flag is 0.
- R4: With function code 2'b11, the result equals the bitwise inversion of A and the carry flag is 0.
- R5: For every code other than 2'b01, the carry flag is 0 whatever the operands are, including all-ones operands.
- R6: The lowest slice receives a carry-in of 0, so adding zero to zero gives a result of 0 and a carry flag of 0.
- R7: A carry ripples through every slice: in add mode, all-ones plus one gives a result of 0 and a carry flag of 1.
- R8: With function codes 2'b00 and 2'b11, operand B has no effect on the result or the carry flag.
- R9: Each slice's full adder produces the 2-bit sum of its two operand bits and its carry-in, built only from gate primitives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH (4) | Operand A, bit WIDTH-1 is the most significant |
| b_i | input | WIDTH (4) | Operand B, bit WIDTH-1 is the most significant |
| sel_i | input | 2 | Function code: 00 pass A, 01 add, 10 AND, 11 invert A |
| res_o | output | WIDTH (4) | Result, bit WIDTH-1 is the most significant |
| cout_o | output | 1 | Carry leaving the top slice; nonzero only in add mode |

## Verification
The bench builds the unit with its default width of four bits. At that width there are 1024 combinations of both operands and the function code, so every combination is applied once and compared against a reference computed in the bench. Because every case is covered, every carry pattern is covered too: the full ripple from the lowest slice to the top, the masked carries in the non-add modes, and the zero carry into the lowest slice. Extra directed cases then hold A fixed and sweep B in the pass and invert modes, to show that B has no effect there.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_AND  = 2'b10,
    OP_NOTA = 2'b11
  } op_e;
endpackage

// File: rtl/bsalu_fa.sv
module bsalu_fa (
  input  wire a_i,
  input  wire b_i,
  input  wire c_i,
  output wire s_o,
  output wire c_o
);
  wire half_p;
  wire gen_g;
  wire prop_t;

  xor g_x0 (half_p, a_i, b_i);
  xor g_x1 (s_o, half_p, c_i);
  and g_a0 (gen_g, a_i, b_i);
  and g_a1 (prop_t, half_p, c_i);
  or  g_o0 (c_o, gen_g, prop_t);

  logic [1:0] fa_ref;
  always_comb begin
    fa_ref = {1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i};
    AST_FA_TOTAL: assert ({c_o, s_o} == fa_ref) else $error("full adder mismatch"); // R9
  end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic ci_i,
  input  op_e  op_i,
  output logic r_o,
  output logic co_o
);
  wire fa_sum;
  wire fa_cy;

  bsalu_fa u_fa (
    .a_i (a_i),
    .b_i (b_i),
    .c_i (ci_i),
    .s_o (fa_sum),
    .c_o (fa_cy)
  );

  always_comb begin
    case (op_i)
      OP_PASS: r_o = a_i;
      OP_ADD:  r_o = fa_sum;
      OP_AND:  r_o = a_i & b_i;
      default: r_o = ~a_i;
    endcase
  end

  assign co_o = (op_i == OP_ADD) & fa_cy;
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  op_e          op;
  logic [WIDTH:0] chain;

  assign op       = op_e'(sel_i);
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    bsalu_slice u_slice (
      .a_i  (a_i[k]),
      .b_i  (b_i[k]),
      .ci_i (chain[k]),
      .op_i (op),
      .r_o  (res_o[k]),
      .co_o (chain[k+1])
    );
  end

  assign cout_o = chain[WIDTH];

  logic [WIDTH:0] add_ref;
  always_comb begin
    add_ref = {1'b0, a_i} + {1'b0, b_i};
    if (sel_i == 2'b00) begin
      AST_PASS_A: assert (res_o == a_i) else $error("pass mismatch"); // R1
    end
    if (sel_i == 2'b01) begin
      AST_ADD_SUM: assert ({cout_o, res_o} == add_ref) else $error("add mismatch"); // R2
    end
    if (sel_i == 2'b10) begin
      AST_AND_AB: assert (res_o == (a_i & b_i)) else $error("and mismatch"); // R3
    end
    if (sel_i == 2'b11) begin
      AST_NOT_A: assert ((res_o ^ a_i) == {WIDTH{1'b1}}) else $error("invert mismatch"); // R4
    end
    if (sel_i != 2'b01) begin
      AST_NO_CARRY: assert (cout_o == 1'b0) else $error("stray carry"); // R5
    end
    if (sel_i == 2'b01 && a_i == '0 && b_i == '0) begin
      AST_LSB_CIN_ZERO: assert (res_o == '0 && !cout_o) else $error("lsb carry-in"); // R6
    end
    if (sel_i == 2'b01 && a_i[MSB:0] == {WIDTH{1'b1}} && b_i == WIDTH'(1)) begin
      AST_FULL_RIPPLE: assert (res_o == '0 && cout_o) else $error("ripple"); // R7
    end
  end
endmodule

// File: tb/bsalu_top_tb.sv
`timescale 1ns/1ps
module bsalu_top_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [1:0]   sel;
  logic [W-1:0] res;
  logic         cout;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bsalu_top #(.WIDTH(W)) u_dut (
    .a_i (a), .b_i (b), .sel_i (sel), .res_o (res), .cout_o (cout)
  );

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [1:0] ts);
    @(negedge clk);
    a = ta; b = tb; sel = ts;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [W-1:0] er, input logic ec);
    n_chk++;
    if (res !== er || cout !== ec) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sel=%b actual res=%h cout=%b expected res=%h cout=%b",
               req, a, b, sel, res, cout, er, ec);
    end
  endtask

  task automatic t_idle;
    apply('0, '0, 2'b00);
    expect_out("R1 idle", '0, 1'b0);
  endtask

  task automatic t_sweep_mode(input logic [1:0] m);
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        logic [W:0] s;
        apply(W'(i), W'(j), m);
        s = W'(i) + W'(j) + (W+1)'(0);
        s = (W+1)'(i + j);
        case (m)
          2'b00: expect_out("R1 pass", W'(i), 1'b0);
          2'b01: expect_out("R2 add", s[W-1:0], s[W]);
          2'b10: expect_out("R3 and", W'(i) & W'(j), 1'b0);
          default: expect_out("R4 invert", ~W'(i), 1'b0);
        endcase
      end
    end
  endtask

  task automatic t_carry_masked;
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        apply('1, '1, 2'(m));
        n_chk++;
        if (cout !== 1'b0) begin
          n_fail++;
          $display("FAIL R5 sel=%0d actual cout=%b expected 0", m, cout);
        end
      end
    end
  endtask

  task automatic t_zero_cin;
    apply('0, '0, 2'b01);
    expect_out("R6 zero plus zero", '0, 1'b0);
    apply(W'(5), '0, 2'b01);
    expect_out("R6 no implicit increment", W'(5), 1'b0);
  endtask

  task automatic t_ripple;
    apply('1, W'(1), 2'b01);
    expect_out("R7 full ripple", '0, 1'b1);
    apply(W'(1), '1, 2'b01);
    expect_out("R7 full ripple swapped", '0, 1'b1);
  endtask

  task automatic t_b_ignored;
    for (int j = 0; j < (1 << W); j++) begin
      apply(W'(4'b1010), W'(j), 2'b00);
      expect_out("R8 pass ignores B", W'(4'b1010), 1'b0);
      apply(W'(4'b0110), W'(j), 2'b11);
      expect_out("R8 invert ignores B", W'(4'b1001), 1'b0);
    end
  endtask

  task automatic t_slice_adder;
    apply(W'(4'b0101), W'(4'b0101), 2'b01);
    expect_out("R9 alternating carries", W'(4'b1010), 1'b0);
    apply(W'(4'b1000), W'(4'b1000), 2'b01);
    expect_out("R9 top slice carry", '0, 1'b1);
  endtask

  initial begin
    a = '0; b = '0; sel = '0;
    t_idle();
    for (int m = 0; m < 4; m++) t_sweep_mode(2'(m));
    t_carry_masked();
    t_zero_cin();
    t_ripple();
    t_b_ignored();
    t_slice_adder();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(400_000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule